// File: doc/BRIEF.md
# I2C Byte Buffer Pair with Level Thresholds

This block holds the bytes that move between a register-mapped data port and a serial shift engine of an I2C controller. It has one byte FIFO for each direction. The host pushes outgoing bytes into the transmit FIFO and the shift engine pops them. The shift engine pushes incoming bytes into the receive FIFO and the host pops them.

Each direction has its own programmable threshold, held in a 16-bit buffer control word. The block compares each fill level against its threshold and raises a ready flag. It also compares the number of bytes still left in the current transfer against the same threshold and raises a drain flag, so that the host can move a final short batch of bytes. A flag that can later be driven into a DMA request line only needs one of these level signals.

The block also detects errors. An engine push into a full receive FIFO is lost and sets a sticky overrun flag. An engine pop from an empty transmit FIFO sets a sticky underflow flag. The build-time depth is reported to software as a 2-bit code.

Top module: `i2c_fifo_pair`

## Requirements
- R1: Synchronous active-high reset, with the following state afterwards:
  - both FIFOs are empty and both levels read 0;
  - both error flags are 0;
  - both threshold fields are 0;
  - both data outputs are 0.
- R2: Each FIFO delivers bytes in the order they were pushed.
  - A pop is accepted only when the level at the start of the cycle is nonzero.
  - The popped byte appears on the data output in the cycle after the pop and holds until the next accepted pop.
  - The level output follows each accepted push and pop in the same clock edge.
- R3: An engine push into a receive FIFO whose level at the start of the cycle equals the depth is dropped and sets `rx_overrun`. The flag stays set until the receive FIFO is cleared. A host push into a full transmit FIFO is ignored, and the transmit level is unchanged.
- R4: An engine pop from an empty transmit FIFO sets `tx_underflow`, which stays set until the transmit FIFO is cleared. A host pop from an empty receive FIFO is ignored: the level stays 0 and `host_rx_data` keeps its value.
- R5: The receive threshold field (control bits 13:8) holds the threshold minus 1. `rx_ready` is 1 when the receive level is at or above that threshold.
- R6: The transmit threshold field (control bits 5:0) holds the threshold minus 1. `tx_ready` is 1 when the free space (depth minus transmit level) is at or above that threshold.
- R7: `xfer_remain` is registered once. The flags use the registered value. `rx_drain` is 1 when that value is below the receive threshold and the receive level is nonzero.
- R8: `tx_drain` is 1 when the registered remaining count is below the transmit threshold and also greater than the transmit level.
- R9: A control write with bit 14 set empties the receive FIFO in that clock edge and clears `rx_overrun`. A control write with bit 6 set does the same for the transmit FIFO and clears `tx_underflow`.
  - A push or pop on the cleared FIFO in that same cycle is discarded.
  - Both clear bits always read back as 0.
  - The read-back word `ctrl_rd` is {2'b00, receive field, 2'b00, transmit field}.
- R10: `depth_code` equals log2(depth) minus 3: 0 for 8 bytes, 1 for 16, 2 for 32 and 3 for 64. The default build has a depth of 32, so the code is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the buffer control word |
| cfg_wdata | input | 16 | Control word: rx clear 14, rx field 13:8, tx clear 6, tx field 5:0 |
| ctrl_rd | output | 16 | Read-back of the control word, with the clear bits reading 0 |
| host_tx_wr | input | 1 | Host push into the transmit FIFO |
| host_tx_data | input | DATA_W | Byte pushed by the host |
| eng_tx_rd | input | 1 | Engine pop from the transmit FIFO |
| eng_tx_data | output | DATA_W | Byte popped by the engine, valid the cycle after the pop |
| eng_rx_wr | input | 1 | Engine push into the receive FIFO |
| eng_rx_data | input | DATA_W | Byte pushed by the engine |
| host_rx_rd | input | 1 | Host pop from the receive FIFO |
| host_rx_data | output | DATA_W | Byte popped by the host, valid the cycle after the pop |
| xfer_remain | input | CNT_W | Bytes remaining in the current transfer |
| tx_level | output | ADDR_W+1 | Transmit fill level |
| rx_level | output | ADDR_W+1 | Receive fill level |
| tx_ready | output | 1 | Transmit free space at or above the threshold |
| rx_ready | output | 1 | Receive level at or above the threshold |
| tx_drain | output | 1 | End-of-transfer transmit request |
| rx_drain | output | 1 | End-of-transfer receive request |
| rx_overrun | output | 1 | Sticky receive overrun |
| tx_underflow | output | 1 | Sticky transmit underflow |
| depth_code | output | 2 | Build-time depth code |

## Verification
The bench drives the following corner cases:
- **Receive FIFO past full.** A design that lets the 33rd byte overwrite stored data, or that fails to raise overrun, shows a wrong level or a wrong byte order on readback.
- **Pops on empty FIFOs.** A design that moves its read pointer here corrupts later data. A design that fails to flag an engine pop on an empty transmit FIFO shows no underflow.
- **Thresholds at exact equality.** These catch an off-by-one in the minus-one field encoding or a strict comparison where an inclusive one is required.
- **Clear coinciding with a push.** This catches a design that lets the byte land after the clear or keeps a stale error flag.

A long mixed run compares every output against a queue-based model on each cycle.

// File: rtl/i2cfq_pkg.sv
package i2cfq_pkg;
  localparam int CTRL_W     = 16;
  localparam int THR_W      = 6;
  localparam int RX_CLR_BIT = 14;
  localparam int RX_THR_LSB = 8;
  localparam int TX_CLR_BIT = 6;
  localparam int TX_THR_LSB = 0;

  typedef logic [THR_W-1:0] thr_field_t;

  typedef struct packed {
    logic ready;
    logic drain;
  } dir_flags_t;

  function automatic logic [1:0] depth_code_f(input int log2_depth);
    return 2'(log2_depth - 3);
  endfunction
endpackage

// File: rtl/buf_ctrl_reg.sv
module buf_ctrl_reg
  import i2cfq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  output thr_field_t        rx_field,
  output thr_field_t        tx_field,
  output logic              rx_clr,
  output logic              tx_clr,
  output logic [CTRL_W-1:0] rd_word
);
  // Clear strobes act in the write cycle and are never stored.
  assign rx_clr = wr && wdata[RX_CLR_BIT];
  assign tx_clr = wr && wdata[TX_CLR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_field <= '0;
      tx_field <= '0;
    end else if (wr) begin
      rx_field <= wdata[RX_THR_LSB +: THR_W];
      tx_field <= wdata[TX_THR_LSB +: THR_W];
    end
  end

  always_comb begin
    rd_word = '0;
    rd_word[RX_THR_LSB +: THR_W] = rx_field;
    rd_word[TX_THR_LSB +: THR_W] = tx_field;
  end
endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic [ADDR_W:0]   level,
  output logic              full,
  output logic              empty,
  output logic              push_drop,
  output logic              pop_miss
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wptr, rptr;
  logic              do_push, do_pop;

  assign full      = (level == (ADDR_W+1)'(DEPTH));
  assign empty     = (level == '0);
  assign do_push   = push && !full  && !clr;
  assign do_pop    = pop  && !empty && !clr;
  assign push_drop = push && full  && !clr;
  assign pop_miss  = pop  && empty && !clr;

  // Storage without reset so that block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_data <= '0;
    end else if (do_pop) begin
      pop_data <= mem[rptr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    level <= (ADDR_W+1)'(DEPTH));

  assert_empty_pop_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (pop && empty && !push && !clr) |=> (level == '0));

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (level == '0));
endmodule

// File: rtl/fifo_flags.sv
module fifo_flags
  import i2cfq_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 16,
  parameter bit IS_TX  = 1'b0
) (
  input  logic [ADDR_W:0]  level,
  input  thr_field_t       thr_field,
  input  logic [CNT_W-1:0] remain,
  output dir_flags_t       flags
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BIG   = (CNT_W > THR_W + 1) ? CNT_W : THR_W + 1;
  localparam int CMP_W = ((BIG > ADDR_W + 1) ? BIG : ADDR_W + 1) + 1;

  logic [CMP_W-1:0] thr_x, lvl_x, rem_x;

  assign thr_x = CMP_W'(thr_field) + CMP_W'(1);
  assign lvl_x = CMP_W'(level);
  assign rem_x = CMP_W'(remain);

  generate
    if (IS_TX) begin : g_tx
      logic [CMP_W-1:0] free_x;
      assign free_x      = CMP_W'(DEPTH) - lvl_x;
      assign flags.ready = (free_x >= thr_x);
      assign flags.drain = (rem_x < thr_x) && (rem_x > lvl_x);
    end else begin : g_rx
      assign flags.ready = (lvl_x >= thr_x);
      assign flags.drain = (rem_x < thr_x) && (lvl_x != '0);
    end
  endgenerate
endmodule

// File: rtl/i2c_fifo_pair.sv
module i2c_fifo_pair
  import i2cfq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       ctrl_rd,
  input  logic              host_tx_wr,
  input  logic [DATA_W-1:0] host_tx_data,
  input  logic              eng_tx_rd,
  output logic [DATA_W-1:0] eng_tx_data,
  input  logic              eng_rx_wr,
  input  logic [DATA_W-1:0] eng_rx_data,
  input  logic              host_rx_rd,
  output logic [DATA_W-1:0] host_rx_data,
  input  logic [CNT_W-1:0]  xfer_remain,
  output logic [ADDR_W:0]   tx_level,
  output logic [ADDR_W:0]   rx_level,
  output logic              tx_ready,
  output logic              rx_ready,
  output logic              tx_drain,
  output logic              rx_drain,
  output logic              rx_overrun,
  output logic              tx_underflow,
  output logic [1:0]        depth_code
);
  thr_field_t       rx_field, tx_field;
  logic             rx_clr, tx_clr;
  logic             rx_full, rx_empty, rx_drop, rx_miss;
  logic             tx_full, tx_empty, tx_drop, tx_miss;
  logic [CNT_W-1:0] remain_q;
  dir_flags_t       rx_flags, tx_flags;

  buf_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wdata(cfg_wdata),
    .rx_field(rx_field), .tx_field(tx_field),
    .rx_clr(rx_clr), .tx_clr(tx_clr), .rd_word(ctrl_rd)
  );

  byte_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_txf (
    .clk(clk), .rst(rst), .clr(tx_clr),
    .push(host_tx_wr), .push_data(host_tx_data),
    .pop(eng_tx_rd), .pop_data(eng_tx_data),
    .level(tx_level), .full(tx_full), .empty(tx_empty),
    .push_drop(tx_drop), .pop_miss(tx_miss)
  );

  byte_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rxf (
    .clk(clk), .rst(rst), .clr(rx_clr),
    .push(eng_rx_wr), .push_data(eng_rx_data),
    .pop(host_rx_rd), .pop_data(host_rx_data),
    .level(rx_level), .full(rx_full), .empty(rx_empty),
    .push_drop(rx_drop), .pop_miss(rx_miss)
  );

  always_ff @(posedge clk) begin
    if (rst) remain_q <= '0;
    else     remain_q <= xfer_remain;
  end

  // Sticky error flags, cleared only by their FIFO clear.
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_overrun   <= 1'b0;
      tx_underflow <= 1'b0;
    end else begin
      if (rx_clr)       rx_overrun   <= 1'b0;
      else if (rx_drop) rx_overrun   <= 1'b1;
      if (tx_clr)       tx_underflow <= 1'b0;
      else if (tx_miss) tx_underflow <= 1'b1;
    end
  end

  fifo_flags #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .IS_TX(1'b0)) u_rxflg (
    .level(rx_level), .thr_field(rx_field), .remain(remain_q), .flags(rx_flags)
  );

  fifo_flags #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .IS_TX(1'b1)) u_txflg (
    .level(tx_level), .thr_field(tx_field), .remain(remain_q), .flags(tx_flags)
  );

  assign rx_ready   = rx_flags.ready;
  assign rx_drain   = rx_flags.drain;
  assign tx_ready   = tx_flags.ready;
  assign tx_drain   = tx_flags.drain;
  assign depth_code = depth_code_f(ADDR_W);

  assert_overrun_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_overrun) |-> $past(eng_rx_wr && rx_full));

  assert_underflow_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_underflow) |-> $past(eng_tx_rd && tx_empty));

  assert_ready_needs_data_R5: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> (rx_level != '0));

  assert_rx_drain_data_R7: assert property (@(posedge clk) disable iff (rst)
    rx_drain |-> !rx_empty);

  assert_tx_drain_remain_R8: assert property (@(posedge clk) disable iff (rst)
    tx_drain |-> (remain_q != '0));
endmodule

// File: tb/sim_i2c_fifo_pair.sv
module sim_i2c_fifo_pair;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 5;
  localparam int DEPTH = 1 << AW;
  localparam int CW    = 16;

  logic clk = 1'b0;
  logic rst;
  logic cfg_wr;
  logic [15:0] cfg_wdata, ctrl_rd;
  logic host_tx_wr, eng_tx_rd, eng_rx_wr, host_rx_rd;
  logic [7:0] host_tx_data, eng_tx_data, eng_rx_data, host_rx_data;
  logic [CW-1:0] xfer_remain;
  logic [AW:0] tx_level, rx_level;
  logic tx_ready, rx_ready, tx_drain, rx_drain, rx_overrun, tx_underflow;
  logic [1:0] depth_code;

  i2c_fifo_pair #(.DATA_W(8), .ADDR_W(AW), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .ctrl_rd(ctrl_rd),
    .host_tx_wr(host_tx_wr), .host_tx_data(host_tx_data),
    .eng_tx_rd(eng_tx_rd), .eng_tx_data(eng_tx_data),
    .eng_rx_wr(eng_rx_wr), .eng_rx_data(eng_rx_data),
    .host_rx_rd(host_rx_rd), .host_rx_data(host_rx_data),
    .xfer_remain(xfer_remain), .tx_level(tx_level), .rx_level(rx_level),
    .tx_ready(tx_ready), .rx_ready(rx_ready), .tx_drain(tx_drain), .rx_drain(rx_drain),
    .rx_overrun(rx_overrun), .tx_underflow(tx_underflow), .depth_code(depth_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0] rxq[$];
  logic [7:0] txq[$];
  logic [7:0] m_rxd, m_txd;
  bit m_ovr, m_udf;
  int m_rxf, m_txf, m_rem;

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit full;
    if (rst) begin
      rxq.delete(); txq.delete();
      m_rxd = 0; m_txd = 0; m_ovr = 0; m_udf = 0;
      m_rxf = 0; m_txf = 0; m_rem = 0;
    end else begin
      m_rem = int'(xfer_remain);
      if (cfg_wr && cfg_wdata[14]) begin
        rxq.delete(); m_ovr = 0;
      end else begin
        full = (rxq.size() == DEPTH);
        if (host_rx_rd && rxq.size() != 0) m_rxd = rxq.pop_front();
        if (eng_rx_wr) begin
          if (full) m_ovr = 1;
          else rxq.push_back(eng_rx_data);
        end
      end
      if (cfg_wr && cfg_wdata[6]) begin
        txq.delete(); m_udf = 0;
      end else begin
        full = (txq.size() == DEPTH);
        if (eng_tx_rd) begin
          if (txq.size() != 0) m_txd = txq.pop_front();
          else m_udf = 1;
        end
        if (host_tx_wr && !full) txq.push_back(host_tx_data);
      end
      if (cfg_wr) begin
        m_rxf = int'(cfg_wdata[13:8]);
        m_txf = int'(cfg_wdata[5:0]);
      end
    end
  endtask

  task automatic compare_all();
    int rthr, tthr;
    rthr = m_rxf + 1;
    tthr = m_txf + 1;
    check("R2", "rx_level", int'(rx_level), rxq.size());
    check("R2", "tx_level", int'(tx_level), txq.size());
    check("R2", "host_rx_data", int'(host_rx_data), int'(m_rxd));
    check("R2", "eng_tx_data", int'(eng_tx_data), int'(m_txd));
    check("R3", "rx_overrun", int'(rx_overrun), int'(m_ovr));
    check("R4", "tx_underflow", int'(tx_underflow), int'(m_udf));
    check("R5", "rx_ready", int'(rx_ready), int'(rxq.size() >= rthr));
    check("R6", "tx_ready", int'(tx_ready), int'((DEPTH - txq.size()) >= tthr));
    check("R7", "rx_drain", int'(rx_drain), int'(m_rem < rthr && rxq.size() != 0));
    check("R8", "tx_drain", int'(tx_drain), int'(m_rem < tthr && m_rem > txq.size()));
    check("R9", "ctrl_rd", int'(ctrl_rd), (m_rxf << 8) | m_txf);
    check("R10", "depth_code", int'(depth_code), 2);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    cfg_wr = 0; host_tx_wr = 0; eng_tx_rd = 0; eng_rx_wr = 0; host_rx_rd = 0;
  endtask

  task automatic wr_ctrl(input logic [15:0] w);
    cfg_wr = 1; cfg_wdata = w; cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1; cfg_wr = 0; cfg_wdata = 0;
    host_tx_wr = 0; host_tx_data = 0; eng_tx_rd = 0;
    eng_rx_wr = 0; eng_rx_data = 0; host_rx_rd = 0; xfer_remain = 0;
    repeat (3) cyc();
    rst = 0;
    cyc();
    // R1 reset state
    check("R1", "rx_level", int'(rx_level), 0);
    check("R1", "tx_level", int'(tx_level), 0);
    check("R1", "errors", int'({rx_overrun, tx_underflow}), 0);
    check("R1", "ctrl_rd", int'(ctrl_rd), 0);
    check("R1", "tx_ready", int'(tx_ready), 1);
    check("R1", "rx_ready", int'(rx_ready), 0);

    // R2 ordering on transmit
    for (int i = 0; i < 5; i++) begin
      host_tx_wr = 1; host_tx_data = 8'(8'hA0 + i); cyc();
    end
    for (int i = 0; i < 5; i++) begin
      eng_tx_rd = 1; cyc();
      check("R2", "tx order", int'(eng_tx_data), 8'hA0 + i);
    end

    // R3 receive overrun past full
    for (int i = 0; i < DEPTH + 2; i++) begin
      eng_rx_wr = 1; eng_rx_data = 8'(i + 1); cyc();
    end
    check("R3", "overrun set", int'(rx_overrun), 1);
    check("R3", "level at depth", int'(rx_level), DEPTH);
    // R4 host pops beyond empty
    for (int i = 0; i < DEPTH + 2; i++) begin
      host_rx_rd = 1; cyc();
    end
    check("R4", "data held after empty pops", int'(host_rx_data), DEPTH);
    // R4 engine underflow
    eng_tx_rd = 1; cyc();
    check("R4", "underflow set", int'(tx_underflow), 1);

    // R5/R6 thresholds: rx thr 4, tx thr 10
    wr_ctrl(16'h0309);
    for (int i = 0; i < 5; i++) begin
      eng_rx_wr = 1; eng_rx_data = 8'(i); cyc();
      check("R5", "rx_ready vs level", int'(rx_ready), int'(i + 1 >= 4));
    end
    for (int i = 0; i < 25; i++) begin
      host_tx_wr = 1; host_tx_data = 8'(i); cyc();
    end
    check("R6", "tx_ready free 7 thr 10", int'(tx_ready), 0);
    eng_tx_rd = 1; cyc(); eng_tx_rd = 1; cyc(); eng_tx_rd = 1; cyc();
    check("R6", "tx_ready free 10 thr 10", int'(tx_ready), 1);

    // R7/R8 remaining-count sweep
    for (int r = 0; r < 14; r++) begin
      xfer_remain = CW'(r); cyc();
    end
    xfer_remain = 3; cyc();
    check("R7", "rx_drain remain 3", int'(rx_drain), 1);
    check("R8", "tx_drain remain 3 level 22", int'(tx_drain), 0);

    // R9 clear both with colliding push
    cfg_wr = 1; cfg_wdata = 16'h4745; eng_rx_wr = 1; host_tx_wr = 1; cyc();
    check("R9", "rx empty after clear", int'(rx_level), 0);
    check("R9", "tx empty after clear", int'(tx_level), 0);
    check("R9", "overrun cleared", int'(rx_overrun), 0);
    check("R9", "underflow cleared", int'(tx_underflow), 0);
    check("R9", "clear bits read 0", int'(ctrl_rd), 16'h0705);
    xfer_remain = 4; cyc();
    check("R8", "tx_drain remain 4 empty", int'(tx_drain), 1);

    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      cfg_wr       = (($urandom % 97) == 0);
      cfg_wdata    = 16'($urandom);
      host_tx_wr   = (($urandom % 3) == 0);
      host_tx_data = 8'($urandom);
      eng_tx_rd    = (($urandom % 3) == 0);
      eng_rx_wr    = (($urandom % 2) == 0);
      eng_rx_data  = 8'($urandom);
      host_rx_rd   = (($urandom % 3) == 0);
      xfer_remain  = CW'($urandom % 70);
      cyc();
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule